// File: doc/BRIEF.md
# Incremental Encoder Position Decoder

This block turns the phase and index outputs of a rotary or linear incremental encoder into a signed-direction position count. The three raw inputs may change at any time with respect to the clock. Each passes through a two-stage synchroniser and then an optional glitch filter whose hold time can be programmed. After that, a per-input inversion and an optional exchange of the two phases are applied. Every edge of either phase moves the count by one step (x4 decoding).

The count runs from zero up to a programmed ceiling and wraps at both ends. In index-reset mode, an index pulse that arrives while the two phases sit at a programmed level pair clears the count. Four sticky event flags record direction changes, resets while counting up or down, and phase errors. Each flag can be routed to a single interrupt output. All configuration arrives on plain input ports and is captured on a write strobe. Only the interrupt enables may be written while the block is enabled; every other field is held fixed until the block is disabled.

Top module: `quad_decoder`

## Requirements
- R1: Each accepted edge of either conditioned phase moves `count` by one. The count goes up when phase A leads phase B, following the state sequence {A,B} = 00, 10, 11, 01, 00, and goes down on the reverse sequence. `dir_up` shows the direction of the last step and is 1 after reset.
- R2: A step up from `count` equal to the ceiling gives 0, and a step down from 0 gives the ceiling.
- R3: When the reset-mode bit is 1, index pulses have no effect. When it is 0, a rising edge of the conditioned index clears `count` to 0, provided it arrives while the phases match the gating field.
- R4: Gating field encoding (bit 1 is the required A level, bit 0 the required B level): 0 = A low and B low, 1 = A low and B high, 2 = A high and B low, 3 = A high and B high. An index edge at any other phase state is ignored.
- R5: `cfg_inv_a`, `cfg_inv_b` and `cfg_inv_idx` each invert their input. `cfg_swap` exchanges phases A and B after inversion. Inverting one phase, or swapping the phases, reverses the counting sense.
- R6: With the filter on and length value N, a filtered input follows a change only after the synchronised input has held the new level for N+2 consecutive clocks. Shorter pulses are discarded. With the filter off, the synchronised inputs pass straight through.
- R7: If both phases change in the same accepted sample, flag bit 0 is set, the count does not change, and an index edge in that sample is ignored.
- R8: `flags` bit assignment is: bit 0 phase error, bit 1 reset while counting down, bit 2 reset while counting up, bit 3 direction change. "Reset" here means a wrap or an index clear. Flags are sticky, and each is cleared by a one on the matching `flag_clr` bit. A new event wins over a clear in the same cycle.
- R9: `irq` is high when any flag whose bit is set in the interrupt-enable field is high. After reset the enable field is 0, so every source is masked. The enable field is written on `cfg_we` at any time.
- R10: The ceiling, filter, reset mode, gating, inversion and swap fields are captured on `cfg_we` only while `enable` is low. A write while `enable` is high leaves them unchanged.
- R11: While `enable` is low, `count` is 0 and phase and index activity neither moves the count nor sets flags.
- R12: Reset state: `count` 0, `dir_up` 1, `flags` 0, `irq` 0. The ceiling resets to all ones, the filter is off, ceiling-reset mode is selected, and there is no inversion or swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Decoder run enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ceiling | input | CW | Highest count value |
| cfg_flt_len | input | FW | Filter length value N (hold time N+2 clocks) |
| cfg_flt_en | input | 1 | Filter on |
| cfg_rst_on_ceil | input | 1 | 1: wrap only, index ignored; 0: index clears count |
| cfg_idx_gate | input | 2 | Phase state in which the index is honoured |
| cfg_inv_a | input | 1 | Invert phase A |
| cfg_inv_b | input | 1 | Invert phase B |
| cfg_inv_idx | input | 1 | Invert index |
| cfg_swap | input | 1 | Exchange phases A and B |
| cfg_irq_en | input | NFLAG | Per-flag interrupt enable |
| flag_clr | input | NFLAG | Write-one-to-clear strobe for flags |
| in_a | input | 1 | Raw phase A |
| in_b | input | 1 | Raw phase B |
| in_idx | input | 1 | Raw index |
| count | output | CW | Position count |
| dir_up | output | 1 | Direction of last step |
| flags | output | NFLAG | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
A wrong previous-phase register or a wrong direction decode shows up as a count that is off by one, or that moves the wrong way. This is visible four clocks after the input edge when the filter is off, and N+2 clocks later when it is on. A corrupted filter counter either lets a short glitch through as a count step or delays a real edge past its window. Both are visible on `count` within a few dozen clocks. A lock or gating fault stays hidden until the next wrap or index pulse. For that reason the bench drives the count past a lowered ceiling and pulses the index at both matching and non-matching phase states.

// File: rtl/quad_decoder.sv
module quad_decoder #(
  parameter int CW    = 32,
  parameter int FW    = 21,
  parameter int NFLAG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic [CW-1:0]    cfg_ceiling,
  input  logic [FW-1:0]    cfg_flt_len,
  input  logic             cfg_flt_en,
  input  logic             cfg_rst_on_ceil,
  input  logic [1:0]       cfg_idx_gate,
  input  logic             cfg_inv_a,
  input  logic             cfg_inv_b,
  input  logic             cfg_inv_idx,
  input  logic             cfg_swap,
  input  logic [NFLAG-1:0] cfg_irq_en,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_idx,
  output logic [CW-1:0]    count,
  output logic             dir_up,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  localparam int FCW = FW + 1;

  logic [CW-1:0]    ceil_q;
  logic [FW-1:0]    flt_len_q;
  logic             flt_en_q, rmode_q, swap_q;
  logic [1:0]       gate_q;
  logic [2:0]       inv_q;
  logic [NFLAG-1:0] irq_en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ceil_q    <= '1;
      flt_len_q <= '0;
      flt_en_q  <= 1'b0;
      rmode_q   <= 1'b1;
      swap_q    <= 1'b0;
      gate_q    <= '0;
      inv_q     <= '0;
      irq_en_q  <= '0;
    end else if (cfg_we) begin
      irq_en_q <= cfg_irq_en;
      if (!enable) begin
        ceil_q    <= cfg_ceiling;
        flt_len_q <= cfg_flt_len;
        flt_en_q  <= cfg_flt_en;
        rmode_q   <= cfg_rst_on_ceil;
        swap_q    <= cfg_swap;
        gate_q    <= cfg_idx_gate;
        inv_q     <= {cfg_inv_idx, cfg_inv_b, cfg_inv_a};
      end
    end

  logic [2:0]     s1, s2, filt_q;
  logic [FCW-1:0] fcnt [3];
  logic [FCW-1:0] flim;
  assign flim = {1'b0, flt_len_q} + FCW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      filt_q <= '0;
      for (int i = 0; i < 3; i++) fcnt[i] <= '0;
    end else begin
      s1 <= {in_idx, in_b, in_a};
      s2 <= s1;
      for (int i = 0; i < 3; i++) begin
        if (!flt_en_q || s2[i] == filt_q[i] || fcnt[i] == flim) begin
          filt_q[i] <= s2[i];
          fcnt[i]   <= '0;
        end else begin
          fcnt[i] <= fcnt[i] + FCW'(1);
        end
      end
    end

  logic [2:0] pol;
  logic       ph_a, ph_b, ph_i, pa, pb, pi;
  assign pol  = filt_q ^ inv_q;
  assign ph_a = swap_q ? pol[1] : pol[0];
  assign ph_b = swap_q ? pol[0] : pol[1];
  assign ph_i = pol[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {pa, pb, pi} <= '0;
    else        {pa, pb, pi} <= {ph_a, ph_b, ph_i};

  logic da, db, perr, step, up, idx_hit;
  assign da      = ph_a ^ pa;
  assign db      = ph_b ^ pb;
  assign perr    = da & db;
  assign step    = da ^ db;
  assign up      = da ? (ph_a ^ ph_b) : ~(ph_a ^ ph_b);
  assign idx_hit = !rmode_q && ph_i && !pi && ({ph_a, ph_b} == gate_q) && !perr;

  logic [NFLAG-1:0] set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else if (!enable) begin
      count <= '0;
    end else if (idx_hit) begin
      count <= '0;
    end else if (step) begin
      dir_up <= up;
      if (up) count <= (count == ceil_q) ? '0 : count + CW'(1);
      else    count <= (count == '0) ? ceil_q : count - CW'(1);
    end

  always_comb begin
    set = '0;
    if (enable) begin
      set[0] = perr;
      if (idx_hit) begin
        set[1] = !dir_up;
        set[2] = dir_up;
      end else if (step) begin
        set[1] = !up && (count == '0);
        set[2] = up && (count == ceil_q);
        set[3] = up != dir_up;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | set;

  assign irq = |(flags & irq_en_q);
endmodule

// File: rtl/quad_decoder_chk.sv
module quad_decoder_chk #(
  parameter int CW    = 32,
  parameter int FW    = 21,
  parameter int NFLAG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CW-1:0]    count,
  input logic [CW-1:0]    ceil_q,
  input logic [FW-1:0]    flt_len_q,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] flag_clr
);
  // R11: disabled block holds its count at zero
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> count == '0);

  // R2: the count never exceeds the ceiling
  p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ceil_q);

  // R10: locked fields stay put while enabled
  p_ceil_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(ceil_q));
  p_flt_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(flt_len_q));

  // R8: a flag stays set unless its clear bit was high
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ($past(flags) & ~$past(flag_clr))) == ($past(flags) & ~$past(flag_clr))));

  // R7: a phase error never moves the count
  p_perr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $stable(count));
endmodule

bind quad_decoder quad_decoder_chk #(.CW(CW), .FW(FW), .NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .count(count), .ceil_q(ceil_q),
  .flt_len_q(flt_len_q), .flags(flags), .flag_clr(flag_clr)
);

// File: tb/tb_quad_decoder.sv
`timescale 1ns/1ps
module tb_quad_decoder;
  localparam int CW = 32, FW = 21, NF = 4;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, cfg_we = 1'b0;
  logic [CW-1:0] cfg_ceiling = '1;
  logic [FW-1:0] cfg_flt_len = '0;
  logic cfg_flt_en = 1'b0, cfg_rst_on_ceil = 1'b1, cfg_inv_a = 1'b0, cfg_inv_b = 1'b0;
  logic cfg_inv_idx = 1'b0, cfg_swap = 1'b0;
  logic [1:0] cfg_idx_gate = '0;
  logic [NF-1:0] cfg_irq_en = '0, flag_clr = '0;
  logic in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
  logic [CW-1:0] count;
  logic dir_up, irq;
  logic [NF-1:0] flags;

  always #4 clk = ~clk;

  quad_decoder #(.CW(CW), .FW(FW), .NFLAG(NF)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we), .cfg_ceiling(cfg_ceiling),
    .cfg_flt_len(cfg_flt_len), .cfg_flt_en(cfg_flt_en), .cfg_rst_on_ceil(cfg_rst_on_ceil),
    .cfg_idx_gate(cfg_idx_gate), .cfg_inv_a(cfg_inv_a), .cfg_inv_b(cfg_inv_b),
    .cfg_inv_idx(cfg_inv_idx), .cfg_swap(cfg_swap), .cfg_irq_en(cfg_irq_en),
    .flag_clr(flag_clr), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
    .count(count), .dir_up(dir_up), .flags(flags), .irq(irq));

  typedef struct { logic [CW-1:0] cnt; logic dir; logic [NF-1:0] fl; logic irq; } exp_t;
  exp_t  q_exp[$];
  string q_tag[$];
  int n_cmp = 0, n_bad = 0;
  int pos = 0;
  int settle = 8;
  bit done = 1'b0;

  always @(negedge clk) begin
    while (q_exp.size() > 0) begin
      exp_t e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_cmp++;
      if (count !== e.cnt || dir_up !== e.dir || flags !== e.fl || irq !== e.irq) begin
        n_bad++;
        $display("FAIL %s: got count=%0d dir=%0b flags=%h irq=%0b, expected count=%0d dir=%0b flags=%h irq=%0b",
                 t, count, dir_up, flags, irq, e.cnt, e.dir, e.fl, e.irq);
      end
    end
  end

  task automatic expect_st(string tag, int c, bit d, logic [NF-1:0] f, bit i);
    exp_t e;
    e.cnt = CW'(c); e.dir = d; e.fl = f; e.irq = i;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_pos();
    case (pos & 3)
      0: {in_a, in_b} = 2'b00;
      1: {in_a, in_b} = 2'b10;
      2: {in_a, in_b} = 2'b11;
      default: {in_a, in_b} = 2'b01;
    endcase
  endtask

  task automatic move(int d, int n);
    for (int k = 0; k < n; k++) begin
      pos = (pos + d + 4) & 3;
      drive_pos();
      wait_cyc(settle);
    end
  endtask

  task automatic cfg_write();
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    wait_cyc(2);
  endtask

  task automatic clear_flags();
    flag_clr = '1;
    @(negedge clk);
    flag_clr = '0;
    wait_cyc(1);
  endtask

  task automatic set_en(bit v);
    enable = v;
    wait_cyc(3);
  endtask

  task automatic idx_pulse(bit active_high);
    in_idx = active_high;
    wait_cyc(3);
    in_idx = ~active_high;
    wait_cyc(settle);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    expect_st("R12 reset state", 0, 1, 4'h0, 0);

    cfg_ceiling = 9; cfg_rst_on_ceil = 1'b1;
    cfg_write();
    set_en(1);
    move(1, 3);
    expect_st("R1 count up on A leading", 3, 1, 4'h0, 0);
    move(-1, 5);
    expect_st("R2 R8 down wrap to ceiling, dir change", 8, 0, 4'hA, 0);
    clear_flags();
    expect_st("R8 write-one-to-clear", 8, 0, 4'h0, 0);
    move(1, 2);
    expect_st("R2 R8 up wrap to zero", 0, 1, 4'hC, 0);

    cfg_irq_en = 4'b0100; cfg_ceiling = 2;
    cfg_write();
    expect_st("R9 enabled source raises irq", 0, 1, 4'hC, 1);
    clear_flags();
    expect_st("R9 irq drops after clear", 0, 1, 4'h0, 0);
    move(1, 4);
    expect_st("R10 ceiling write ignored while enabled", 4, 1, 4'h0, 0);

    pos = (pos + 2) & 3;
    drive_pos();
    wait_cyc(settle);
    expect_st("R7 phase error holds count", 4, 1, 4'h1, 0);
    clear_flags();

    set_en(0);
    expect_st("R11 disabled count is zero", 0, 1, 4'h0, 0);
    move(1, 3);
    in_idx = 1'b1; wait_cyc(3); in_idx = 1'b0; wait_cyc(settle);
    expect_st("R11 activity ignored while disabled", 0, 1, 4'h0, 0);

    cfg_ceiling = 9; cfg_swap = 1'b1; cfg_irq_en = '0;
    cfg_write();
    set_en(1);
    move(1, 1);
    expect_st("R5 swap reverses counting", 9, 0, 4'hA, 0);
    clear_flags();
    set_en(0);
    cfg_swap = 1'b0; cfg_inv_a = 1'b1;
    cfg_write();
    set_en(1);
    move(1, 1);
    expect_st("R5 inverted A reverses counting", 9, 0, 4'h2, 0);
    clear_flags();
    set_en(0);

    cfg_inv_a = 1'b0; cfg_rst_on_ceil = 1'b1; cfg_idx_gate = 2'd3;
    cfg_write();
    set_en(1);
    begin
      int k;
      k = 0;
      while (pos != 2) begin move(1, 1); k++; end
      clear_flags();
      idx_pulse(1'b1);
      expect_st("R3 index ignored in ceiling mode", k, (k > 0) ? 1'b1 : 1'b0, 4'h0, 0);
    end
    set_en(0);

    cfg_rst_on_ceil = 1'b0; cfg_idx_gate = 2'd3;
    cfg_write();
    set_en(1);
    move(1, 4);
    clear_flags();
    idx_pulse(1'b1);
    expect_st("R3 R4 index clears at gate 3 (A high B high)", 0, 1, 4'h4, 0);
    move(1, 1);
    idx_pulse(1'b1);
    expect_st("R4 index ignored at A low B high with gate 3", 1, 1, 4'h4, 0);
    set_en(0);

    cfg_idx_gate = 2'd1; cfg_inv_idx = 1'b1;
    cfg_write();
    set_en(1);
    move(1, 4);
    clear_flags();
    idx_pulse(1'b1);
    expect_st("R5 R4 inverted index clears at gate 1", 0, 1, 4'h4, 0);
    set_en(0);

    cfg_inv_idx = 1'b0; cfg_rst_on_ceil = 1'b1; cfg_idx_gate = 2'd0;
    cfg_flt_en = 1'b1; cfg_flt_len = 3;
    cfg_write();
    set_en(1);
    clear_flags();
    settle = 20;
    in_a = ~in_a; wait_cyc(3); in_a = ~in_a; wait_cyc(settle);
    expect_st("R6 short glitch rejected", 0, 1, 4'h0, 0);
    move(1, 1);
    expect_st("R6 held edge accepted", 1, 1, 4'h0, 0);

    done = 1'b1;
    wait_cyc(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule